// File: doc/BRIEF.md
# Break and Main Output Enable Control for a Complementary Output Pair

This block sits between the waveform stage of a PWM timer and the pads of one complementary output pair. For each leg it takes the raw waveform, the leg's enable bit and its idle level. It then decides the level the pad sees, and whether the timer drives the pad at all or leaves it to high impedance. A single main output enable gates both legs. Software sets and clears it. When automatic re-arming is selected, an update event also sets it. A qualified break clears it.

The break input arrives already filtered. A polarity bit gives its active level, and both an enable bit and a disarm bit can neutralise it. A qualified break removes drive from the outputs combinationally, in the cycle it is seen. The register behind the main output enable clears at the following edge. While the break stays active, every attempt to set the enable again is refused. Two off-state selections choose how an inactive leg looks:
- one for the run state, while the main enable is on;
- one for the idle state, while it is off.

Each selection either releases the leg or keeps it driven at a defined level.

Top module: `brk_moe_ctrl`

## Requirements
- R1: The break input counts as active when its level equals the polarity bit: polarity 0 means active low, polarity 1 means active high.
- R2: When break enable is 0 or the disarm bit is 1, the break input has no effect: the main output enable and the outputs behave as if no break were present.
- R3: A qualified break forces the effective main output enable (port `moe_o`) and both leg enables to their off state in the same cycle it appears. The stored enable is 0 after the next edge and stays 0 after the break goes away, until it is set again. While the break is active, neither a software set nor an update event can set it.
- R4: With automatic enable at 1, an update event in a cycle with no active break sets the main output enable at the next edge. With automatic enable at 0, an update event leaves it unchanged.
- R5: A software set pulse sets the main output enable at the next edge, and a software clear pulse clears it. When both arrive in the same cycle, the clear wins (default of parameter `CLR_WINS`).
- R6: With the main output enable at 0 and idle off-state selection at 0, both legs have output enable 0.
- R7: With the main output enable at 0 and idle off-state selection at 1, a leg whose enable bit is 1 drives its idle level with output enable 1. A leg whose enable bit is 0 has output enable 0.
- R8: With the main output enable at 1, a leg whose enable bit is 1 drives its own waveform input with output enable 1. The idle selection and idle levels have no effect.
- R9: With the main output enable at 1, run off-state selection at 0 and a leg's enable bit at 0, that leg has output enable 0.
- R10: With the main output enable at 1 and run off-state selection at 1, a disabled leg drives level 0 with output enable 1 if the other leg's enable bit is 1. If both enable bits are 0, both legs have output enable 0.
- R11: After reset the main output enable is 0 (parameter `MOE_RST_VAL` default).
- R12: Whenever a leg's output enable is 0, its level output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_main | input | 1 | Waveform for the main leg |
| pwm_comp | input | 1 | Waveform for the complementary leg |
| en_main | input | 1 | Main leg enable bit |
| en_comp | input | 1 | Complementary leg enable bit |
| idle_main | input | 1 | Idle level of the main leg |
| idle_comp | input | 1 | Idle level of the complementary leg |
| sw_set | input | 1 | Software set pulse for the main output enable |
| sw_clr | input | 1 | Software clear pulse for the main output enable |
| auto_en | input | 1 | Allows update events to set the main output enable |
| upd_evt | input | 1 | Update event pulse |
| brk_en | input | 1 | Break enable |
| brk_pol | input | 1 | Break active level |
| brk_disarm | input | 1 | 1 disarms the break input |
| off_run_sel | input | 1 | Run-state off-state selection |
| off_idle_sel | input | 1 | Idle-state off-state selection |
| brk_in | input | 1 | Filtered break input |
| out_main | output | 1 | Main leg level |
| oe_main | output | 1 | Main leg output enable |
| out_comp | output | 1 | Complementary leg level |
| oe_comp | output | 1 | Complementary leg output enable |
| moe_o | output | 1 | Effective main output enable |

## Verification
The bench checks that the break cuts drive in the very cycle it is raised. A design that used only the registered enable would still drive the pads for one cycle. It then holds the break and tries a software set and an update event while the break is active. A design that let either win would re-enable the outputs during a fault.

Both break polarities are tested, as are the enable and disarm masks. A wrong polarity or a missed mask would clear the enable on a healthy input or ignore a real fault.

The vector table covers these corners:
- the run-state case where one leg is disabled and the other is enabled, which must keep the disabled leg driven low;
- the case where both legs are disabled, which must release both;
- idle levels that differ between the legs, so a swapped leg shows up.

// File: rtl/brk_pkg.sv
package brk_pkg;
   typedef enum logic [1:0] {
      LEG_OFF    = 2'd0,
      LEG_ACTIVE = 2'd1,
      LEG_IDLE   = 2'd2,
      LEG_INACT  = 2'd3
   } leg_mode_e;

   localparam int unsigned NUM_LEGS = 2;
   localparam int unsigned LEG_MAIN = 0;
   localparam int unsigned LEG_COMP = 1;
endpackage

// File: rtl/brk_qualify.sv
module brk_qualify (
   input  logic brk_in,
   input  logic brk_pol,
   input  logic brk_en,
   input  logic brk_disarm,
   output logic brk_act
);
   logic level_hit;

   always_comb begin
      level_hit = (brk_in == brk_pol);
      brk_act   = level_hit && brk_en && !brk_disarm;
   end
endmodule

// File: rtl/moe_ctrl.sv
module moe_ctrl #(
   parameter bit MOE_RST_VAL = 1'b0,
   parameter bit CLR_WINS    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic brk_act,
   input  logic sw_set,
   input  logic sw_clr,
   input  logic auto_en,
   input  logic upd_evt,
   output logic moe_eff
);
   logic moe_q;
   logic moe_d;
   logic set_req;

   always_comb set_req = sw_set || (auto_en && upd_evt);

   generate
      if (CLR_WINS) begin : g_clr_first
         always_comb begin
            if (brk_act)      moe_d = 1'b0;
            else if (sw_clr)  moe_d = 1'b0;
            else if (set_req) moe_d = 1'b1;
            else              moe_d = moe_q;
         end
      end else begin : g_set_first
         always_comb begin
            if (brk_act)      moe_d = 1'b0;
            else if (set_req) moe_d = 1'b1;
            else if (sw_clr)  moe_d = 1'b0;
            else              moe_d = moe_q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) moe_q <= MOE_RST_VAL;
      else        moe_q <= moe_d;
   end

   always_comb moe_eff = moe_q && !brk_act;

   // R3: a qualified break leaves the stored enable cleared
   a_r3_break_clears: assert property (@(posedge clk) disable iff (!rst_n)
      brk_act |=> !moe_q);
   // R4: update event with auto enable sets the enable
   a_r4_auto_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!brk_act && auto_en && upd_evt && !sw_clr) |=> moe_q);
   // R5: with no request the enable holds
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!brk_act && !sw_set && !sw_clr && !upd_evt) |=> $stable(moe_q));
endmodule

// File: rtl/out_leg.sv
module out_leg
   import brk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic moe_eff,
   input  logic off_run_sel,
   input  logic off_idle_sel,
   input  logic en_self,
   input  logic en_other,
   input  logic idle_lvl,
   input  logic pwm,
   output logic lvl,
   output logic oe
);
   leg_mode_e mode;

   always_comb begin
      if (moe_eff) begin
         if (en_self)                      mode = LEG_ACTIVE;
         else if (off_run_sel && en_other) mode = LEG_INACT;
         else                              mode = LEG_OFF;
      end else begin
         if (off_idle_sel && en_self)      mode = LEG_IDLE;
         else                              mode = LEG_OFF;
      end
   end

   always_comb begin
      unique case (mode)
         LEG_ACTIVE: begin lvl = pwm;      oe = 1'b1; end
         LEG_IDLE:   begin lvl = idle_lvl; oe = 1'b1; end
         LEG_INACT:  begin lvl = 1'b0;     oe = 1'b1; end
         default:    begin lvl = 1'b0;     oe = 1'b0; end
      endcase
   end

   // R6: idle state with release selected never drives
   a_r6_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!moe_eff && !off_idle_sel) |-> !oe);
   // R12: an undriven leg reports level 0
   a_r12_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> !lvl);
   // R8: an enabled leg in the run state follows its waveform
   a_r8_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (moe_eff && en_self) |-> (oe && lvl == pwm));
endmodule

// File: rtl/brk_moe_ctrl.sv
module brk_moe_ctrl
   import brk_pkg::*;
#(
   parameter bit MOE_RST_VAL = 1'b0,
   parameter bit CLR_WINS    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_main,
   input  logic pwm_comp,
   input  logic en_main,
   input  logic en_comp,
   input  logic idle_main,
   input  logic idle_comp,
   input  logic sw_set,
   input  logic sw_clr,
   input  logic auto_en,
   input  logic upd_evt,
   input  logic brk_en,
   input  logic brk_pol,
   input  logic brk_disarm,
   input  logic off_run_sel,
   input  logic off_idle_sel,
   input  logic brk_in,
   output logic out_main,
   output logic oe_main,
   output logic out_comp,
   output logic oe_comp,
   output logic moe_o
);
   generate
      if (NUM_LEGS != 2) begin : g_bad_legs
         $error("brk_moe_ctrl supports exactly one complementary pair");
      end
   endgenerate

   logic brk_act;
   logic moe_eff;
   logic [NUM_LEGS-1:0] pwm_v, en_v, idle_v, lvl_v, oe_v;

   always_comb begin
      pwm_v[LEG_MAIN]  = pwm_main;
      pwm_v[LEG_COMP]  = pwm_comp;
      en_v[LEG_MAIN]   = en_main;
      en_v[LEG_COMP]   = en_comp;
      idle_v[LEG_MAIN] = idle_main;
      idle_v[LEG_COMP] = idle_comp;
   end

   brk_qualify u_qual (
      .brk_in     (brk_in),
      .brk_pol    (brk_pol),
      .brk_en     (brk_en),
      .brk_disarm (brk_disarm),
      .brk_act    (brk_act)
   );

   moe_ctrl #(
      .MOE_RST_VAL (MOE_RST_VAL),
      .CLR_WINS    (CLR_WINS)
   ) u_moe (
      .clk     (clk),
      .rst_n   (rst_n),
      .brk_act (brk_act),
      .sw_set  (sw_set),
      .sw_clr  (sw_clr),
      .auto_en (auto_en),
      .upd_evt (upd_evt),
      .moe_eff (moe_eff)
   );

   for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
      out_leg u_leg (
         .clk          (clk),
         .rst_n        (rst_n),
         .moe_eff      (moe_eff),
         .off_run_sel  (off_run_sel),
         .off_idle_sel (off_idle_sel),
         .en_self      (en_v[i]),
         .en_other     (en_v[NUM_LEGS-1-i]),
         .idle_lvl     (idle_v[i]),
         .pwm          (pwm_v[i]),
         .lvl          (lvl_v[i]),
         .oe           (oe_v[i])
      );
   end

   always_comb begin
      out_main = lvl_v[LEG_MAIN];
      oe_main  = oe_v[LEG_MAIN];
      out_comp = lvl_v[LEG_COMP];
      oe_comp  = oe_v[LEG_COMP];
      moe_o    = moe_eff;
   end

   // R3: a qualified break removes drive in the same cycle
   a_r3_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_en && !brk_disarm && brk_in == brk_pol && !off_idle_sel)
         |-> (!oe_main && !oe_comp));
   // R2: a masked break cannot clear the enable
   a_r2_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (!brk_en && moe_o && !sw_clr) |=> moe_o || brk_en);
endmodule

// File: tb/brk_moe_ctrl_test.sv
module brk_moe_ctrl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm_main = 0, pwm_comp = 0, en_main = 0, en_comp = 0;
   logic idle_main = 0, idle_comp = 0, sw_set = 0, sw_clr = 0;
   logic auto_en = 0, upd_evt = 0, brk_en = 0, brk_pol = 0, brk_disarm = 0;
   logic off_run_sel = 0, off_idle_sel = 0, brk_in = 1;
   logic out_main, oe_main, out_comp, oe_comp, moe_o;
   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   brk_moe_ctrl uut (.*);

   // [12]moe [11]idle_sel [10]run_sel [9]en_m [8]en_c [7]idle_m [6]idle_c
   // [5]pwm_m [4]pwm_c [3]oe_m [2]out_m [1]oe_c [0]out_c
   localparam int NV = 10;
   localparam logic [12:0] VEC [NV] = '{
      13'b0_0_0_11_11_11_0000,  // R6
      13'b0_1_0_11_10_00_1110,  // R7
      13'b0_1_0_10_11_00_1100,  // R7
      13'b1_0_0_11_00_10_1110,  // R8
      13'b1_0_0_11_00_01_1011,  // R8
      13'b1_0_0_10_00_11_1100,  // R9
      13'b1_0_1_01_00_11_1011,  // R10
      13'b1_1_1_00_11_11_0000,  // R10
      13'b1_1_0_11_00_11_1111,  // R8
      13'b0_1_0_01_01_11_0011   // R7
   };

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic pulse_set();
      @(negedge clk); sw_set = 1;
      @(negedge clk); sw_set = 0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); sw_clr = 1;
      @(negedge clk); sw_clr = 0;
   endtask

   initial begin
      #200000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R11 reset state
      repeat (2) @(negedge clk);
      #1 check("R11 reset", {oe_main, oe_comp, moe_o, out_main}, 4'b0000);
      rst_n = 1;
      @(negedge clk);
      #1 check("R11 after reset", {3'b000, moe_o}, 4'b0000);

      // vector table, break disabled
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][12]) pulse_set(); else pulse_clr();
         @(negedge clk);
         off_idle_sel = VEC[i][11]; off_run_sel = VEC[i][10];
         en_main = VEC[i][9]; en_comp = VEC[i][8];
         idle_main = VEC[i][7]; idle_comp = VEC[i][6];
         pwm_main = VEC[i][5]; pwm_comp = VEC[i][4];
         #2 check($sformatf("R6-R10 vec%0d R12", i),
                  {oe_main, out_main, oe_comp, out_comp}, VEC[i][3:0]);
      end

      // R5 clear wins over set
      @(negedge clk); sw_set = 1; sw_clr = 1;
      @(negedge clk); sw_set = 0; sw_clr = 0;
      #1 check("R5 clr wins", {3'b0, moe_o}, 4'b0000);
      pulse_set();
      #1 check("R5 set", {3'b0, moe_o}, 4'b0001);
      pulse_clr();
      #1 check("R5 clear", {3'b0, moe_o}, 4'b0000);

      // R4 automatic enable
      @(negedge clk); upd_evt = 1; auto_en = 0;
      @(negedge clk); upd_evt = 0;
      #1 check("R4 auto off", {3'b0, moe_o}, 4'b0000);
      @(negedge clk); upd_evt = 1; auto_en = 1;
      @(negedge clk); upd_evt = 0;
      #1 check("R4 auto on", {3'b0, moe_o}, 4'b0001);

      // R1/R3 active-high break, same-cycle cut
      en_main = 1; en_comp = 1; off_idle_sel = 0; off_run_sel = 0;
      brk_en = 1; brk_pol = 1; brk_in = 0;
      @(negedge clk);
      #1 check("R1 inactive level", {oe_main, oe_comp, 1'b0, moe_o}, 4'b1101);
      @(negedge clk); brk_in = 1;
      #2 check("R3 same cycle", {oe_main, oe_comp, 1'b0, moe_o}, 4'b0000);
      @(negedge clk); sw_set = 1; upd_evt = 1;
      @(negedge clk); sw_set = 0; upd_evt = 0;
      #1 check("R3 set refused", {3'b0, moe_o}, 4'b0000);
      brk_in = 0; auto_en = 0;
      @(negedge clk);
      #1 check("R3 stays cleared", {oe_main, oe_comp, 1'b0, moe_o}, 4'b0000);

      // R1 active-low break
      pulse_set();
      brk_pol = 0; brk_in = 1;
      @(negedge clk);
      #1 check("R1 low pol idle", {3'b0, moe_o}, 4'b0001);
      brk_in = 0;
      @(negedge clk);
      #1 check("R1 low pol hit", {3'b0, moe_o}, 4'b0000);

      // R2 masks
      brk_in = 1;
      pulse_set();
      brk_en = 0; brk_in = 0;
      repeat (2) @(negedge clk);
      #1 check("R2 brk_en off", {oe_main, oe_comp, 1'b0, moe_o}, 4'b1101);
      brk_en = 1; brk_disarm = 1;
      repeat (2) @(negedge clk);
      #1 check("R2 disarmed", {oe_main, oe_comp, 1'b0, moe_o}, 4'b1101);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule